// File: doc/BRIEF.md
# Run-Length Loss Detector and Lock-Source Selector

This block sits behind a receive deserializer and decides, word by word, whether the clock-recovery loop may follow the incoming data or has to follow the local reference clock. It scans each accepted parallel word for runs of identical bits. It carries the length and polarity of the run that is still open at the end of a word into the next word, so a run that crosses any number of word boundaries is measured exactly. A run that reaches the limit is reported as a loss-of-signal condition on a registered flag.

A two-state controller combines that flag with an external frequency-valid input. While following the reference, it counts consecutive accepted words that show no run fault and a valid frequency. Once a programmable number of such words has been seen, it switches to data lock. Any fault sends it straight back to reference lock. A loopback select replaces the received word stream with the transmit word stream at the input of the checker.

Top module: `rl_lock_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `lock_to_data` is 0 and `run_viol` is 0, and the open run is empty with polarity 0.
- R2: Bit 0 of each accepted word is the earliest bit in time. A run of at least RUN_LIMIT (default 120) identical bits, whether ones or zeros, raises `run_viol` on the clock edge that accepts the word in which the run reaches RUN_LIMIT. With 10-bit words this takes at least 12 words.
- R3: Runs that span word boundaries are counted bit-exactly: a run one bit shorter than RUN_LIMIT never raises `run_viol`, at any alignment within the word.
- R4: After each accepted word, `run_viol` is 1 exactly when a run of at least RUN_LIMIT bits either ended inside that word or is still open at its last bit. The flag therefore stays high while the run continues and clears once a later word brings a transition and no further long run.
- R5: A word is accepted only in a cycle where the selected valid strobe is 1. In other cycles the word value is ignored, and both the run state and `run_viol` are unchanged.
- R6: When `loop_en` is 1, `tx_word`/`tx_valid` are checked in place of `rx_word`/`rx_valid`, and the receive inputs have no effect.
- R7: `lock_to_data` rises on the edge that accepts the Q-th consecutive qualifying word. A qualifying word is an accepted word with `freq_ok` = 1 that raises no run violation. Q is `qual_words`, and a value of 0 acts as 1.
- R8: While `lock_to_data` is 1, a cycle with `freq_ok` = 0 clears it on the next edge.
- R9: An accepted word that raises a run violation clears `lock_to_data` on the same edge on which `run_viol` rises. This word never completes qualification, even if it would have been the Q-th.
- R10: While in reference lock, a cycle with `freq_ok` = 0, or an accepted word with a violation, restarts the qualification count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_word | input | WORD_W | Received parallel word, bit 0 earliest |
| rx_valid | input | 1 | Strobe marking `rx_word` as a new word |
| tx_word | input | WORD_W | Transmit parallel word used in loopback |
| tx_valid | input | 1 | Strobe marking `tx_word` as a new word |
| loop_en | input | 1 | 1 selects the transmit stream for checking |
| freq_ok | input | 1 | Frequency check passes |
| qual_words | input | QUAL_W | Consecutive good words needed before data lock |
| run_viol | output | 1 | Registered run-length violation flag |
| lock_to_data | output | 1 | 1 = follow data, 0 = follow reference |

## Verification
Two functions can land on one clock edge: completion of the qualification count, and detection of a run violation. The bench provokes this collision on purpose. It sets `qual_words` so that the word carrying the RUN_LIMIT-th identical bit would also be the last qualifying word. It then judges that `run_viol` rises on that edge while `lock_to_data` stays 0. A second collision drops `freq_ok` in the same cycle as a good word during qualification, and the bench expects the count to restart. All outputs are compared each cycle against a bit-serial model. That model is swept over run lengths around the limit, every start offset within a word, both polarities, and gaps in the valid strobe.

// File: rtl/rl_lock_pkg.sv
// Package: shared types for the run-length lock-source controller.
// Assumes: nothing beyond standard SystemVerilog.
package rl_lock_pkg;

    // Which source the clock-recovery loop follows.
    typedef enum logic {
        SRC_REF  = 1'b0,
        SRC_DATA = 1'b1
    } lock_src_e;

    // Summary of one word's bit runs, produced by the word scanner.
    typedef struct packed {
        logic first_bit;  // value of bit 0 (earliest)
        logic last_bit;   // value of bit WORD_W-1 (latest)
        logic uniform;    // every bit in the word is equal
    } word_edge_t;

endpackage

// File: rtl/rl_word_scan.sv
// Module: rl_word_scan
// Purpose: purely combinational scan of one word. It reports the length of
//          the leading run (starting at bit 0), the length of the trailing run
//          (ending at the top bit), and whether the whole word is one value.
// Assumes: bit 0 is the earliest received bit; WORD_W >= 2.
module rl_word_scan
    import rl_lock_pkg::*;
#(
    parameter int WORD_W = 10,
    localparam int LEN_W = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] word,
    output logic [LEN_W-1:0]  lead_len,
    output logic [LEN_W-1:0]  trail_len,
    output word_edge_t        edges
);

    logic lead_open;
    logic trail_open;

    // Count bits equal to bit 0, walking forward until the first change.
    always_comb begin
        lead_len  = '0;
        lead_open = 1'b1;
        for (int i = 0; i < WORD_W; i++) begin
            if (lead_open && (word[i] == word[0])) begin
                lead_len = lead_len + LEN_W'(1);
            end else begin
                lead_open = 1'b0;
            end
        end
    end

    // Count bits equal to the top bit, walking backward until the first change.
    always_comb begin
        trail_len  = '0;
        trail_open = 1'b1;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (trail_open && (word[i] == word[WORD_W-1])) begin
                trail_len = trail_len + LEN_W'(1);
            end else begin
                trail_open = 1'b0;
            end
        end
    end

    // Edge summary used by the run counter.
    always_comb begin
        edges.first_bit = word[0];
        edges.last_bit  = word[WORD_W-1];
        edges.uniform   = (lead_len == LEN_W'(WORD_W));
    end

endmodule

// File: rtl/rl_run_counter.sv
// Module: rl_run_counter
// Purpose: holds the open run (length, polarity) across accepted words and
//          produces the registered run-length violation flag. The flag is
//          set when a run of RUN_LIMIT or more bits ended in the word just
//          accepted, or is still open at its end.
// Assumes: RUN_LIMIT > WORD_W, so no run that lies wholly inside one word
//          can reach the limit. The length is saturated at RUN_LIMIT.
module rl_run_counter
    import rl_lock_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int RUN_LIMIT = 120,
    localparam int LEN_W    = $clog2(WORD_W + 1),
    localparam int RUN_W    = $clog2(RUN_LIMIT + WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_v,
    input  logic [WORD_W-1:0] word,
    output logic              run_viol,
    output logic              viol_now
);

    logic [LEN_W-1:0] lead_len;
    logic [LEN_W-1:0] trail_len;
    word_edge_t       edges;

    logic [RUN_W-1:0] run_len_q;
    logic             run_pol_q;
    logic [RUN_W-1:0] run_len_d;
    logic             run_pol_d;
    logic             viol_d;
    logic             cont;
    logic [RUN_W-1:0] ended_len;
    logic [RUN_W-1:0] grown_len;

    rl_word_scan #(.WORD_W(WORD_W)) u_scan (
        .word      (word),
        .lead_len  (lead_len),
        .trail_len (trail_len),
        .edges     (edges)
    );

    // Work out the open run and the violation outcome for this word.
    always_comb begin
        cont      = (edges.first_bit == run_pol_q);
        grown_len = run_len_q + RUN_W'(WORD_W);
        ended_len = cont ? (run_len_q + RUN_W'(lead_len)) : RUN_W'(lead_len);
        if (edges.uniform) begin
            run_pol_d = edges.first_bit;
            run_len_d = cont ? grown_len : RUN_W'(WORD_W);
            if (run_len_d > RUN_W'(RUN_LIMIT)) begin
                run_len_d = RUN_W'(RUN_LIMIT);
            end
            viol_d = (run_len_d >= RUN_W'(RUN_LIMIT));
        end else begin
            run_pol_d = edges.last_bit;
            run_len_d = RUN_W'(trail_len);
            viol_d    = (ended_len >= RUN_W'(RUN_LIMIT));
        end
    end

    // Violation result visible to the lock controller in the accepting cycle.
    assign viol_now = word_v && viol_d;

    // Register the open run and the flag on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len_q <= '0;
            run_pol_q <= 1'b0;
            run_viol  <= 1'b0;
        end else if (word_v) begin
            run_len_q <= run_len_d;
            run_pol_q <= run_pol_d;
            run_viol  <= viol_d;
        end
    end

    // R5: without an accepted word the flag keeps its value.
    assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_v |=> $stable(run_viol));

    // R3: the stored length never exceeds the saturation point.
    assert_run_saturated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run_len_q <= RUN_W'(RUN_LIMIT));

    // R4: a mixed word ends the open run, which then fits inside one word.
    assert_mixed_word_short_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_v && !edges.uniform) |=> (run_len_q < RUN_W'(WORD_W)));

endmodule

// File: rtl/rl_lock_fsm.sv
// Module: rl_lock_fsm
// Purpose: chooses between reference lock and data lock. While following the
//          reference it counts consecutive qualifying words. Any fault drops
//          data lock at once, and any fault seen during qualification
//          restarts the count.
// Assumes: viol_now is high only in a cycle that accepts a word.
module rl_lock_fsm
    import rl_lock_pkg::*;
#(
    parameter int QUAL_W = 4,
    localparam int CNT_W = QUAL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_v,
    input  logic              viol_now,
    input  logic              freq_ok,
    input  logic [QUAL_W-1:0] qual_words,
    output logic              lock_to_data
);

    lock_src_e        state_q;
    lock_src_e        state_d;
    logic [CNT_W-1:0] good_q;
    logic [CNT_W-1:0] good_d;
    logic [CNT_W-1:0] target;
    logic             fault;
    logic             good_word;

    // Qualification target, with a zero setting treated as one word.
    always_comb begin
        target = (qual_words == '0) ? CNT_W'(1) : CNT_W'(qual_words);
    end

    // Classify this cycle as a fault, a good word, or neither.
    always_comb begin
        fault     = !freq_ok || viol_now;
        good_word = word_v && !fault;
    end

    // Next-state and qualification-count logic.
    always_comb begin
        state_d = state_q;
        good_d  = good_q;
        case (state_q)
            SRC_DATA: begin
                good_d = '0;
                if (fault) begin
                    state_d = SRC_REF;
                end
            end
            default: begin
                if (fault) begin
                    good_d = '0;
                end else if (good_word) begin
                    if ((good_q + CNT_W'(1)) >= target) begin
                        state_d = SRC_DATA;
                        good_d  = '0;
                    end else begin
                        good_d = good_q + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRC_REF;
            good_q  <= '0;
        end else begin
            state_q <= state_d;
            good_q  <= good_d;
        end
    end

    assign lock_to_data = (state_q == SRC_DATA);

    // R8: a lost frequency check ends data lock on the next edge.
    assert_freq_loss_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_to_data && !freq_ok) |=> !lock_to_data);

    // R9: a violating word always leaves the loop on the reference.
    assert_viol_forces_ref_R9: assert property (@(posedge clk) disable iff (!rst_n)
        viol_now |=> !lock_to_data);

    // R7: data lock is entered only on a qualifying word.
    assert_entry_needs_good_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_to_data && !good_word) |=> !lock_to_data);

    // R10: the count never reaches the target while still in reference lock.
    assert_count_below_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_to_data |-> (good_q < target));

endmodule

// File: rtl/rl_lock_ctrl.sv
// Module: rl_lock_ctrl (top)
// Purpose: selects the checked word stream (receive or loopback), feeds the
//          run counter, and drives the lock-source controller from the run
//          result and the external frequency flag.
// Assumes: one word per valid strobe; RUN_LIMIT > WORD_W.
module rl_lock_ctrl
    import rl_lock_pkg::*;
#(
    parameter int WORD_W    = 10,
    parameter int RUN_LIMIT = 120,
    parameter int QUAL_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              rx_valid,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_valid,
    input  logic              loop_en,
    input  logic              freq_ok,
    input  logic [QUAL_W-1:0] qual_words,
    output logic              run_viol,
    output logic              lock_to_data
);

    logic [WORD_W-1:0] chk_word;
    logic              chk_valid;
    logic              viol_now;

    // Loopback selection of the word stream under check.
    always_comb begin
        chk_word  = loop_en ? tx_word  : rx_word;
        chk_valid = loop_en ? tx_valid : rx_valid;
    end

    rl_run_counter #(
        .WORD_W    (WORD_W),
        .RUN_LIMIT (RUN_LIMIT)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_v   (chk_valid),
        .word     (chk_word),
        .run_viol (run_viol),
        .viol_now (viol_now)
    );

    rl_lock_fsm #(
        .QUAL_W (QUAL_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_v       (chk_valid),
        .viol_now     (viol_now),
        .freq_ok      (freq_ok),
        .qual_words   (qual_words),
        .lock_to_data (lock_to_data)
    );

    // R2: a raised flag always comes with reference lock on the same edge.
    assert_flag_rise_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_viol) |-> !lock_to_data);

endmodule

// File: tb/rl_lock_ctrl_test.sv
// Bench: bit-serial reference model compared every cycle against the block.
module rl_lock_ctrl_test;

    localparam int W     = 10;
    localparam int LIMIT = 120;
    localparam int QW    = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] rx_word = '0;
    logic         rx_valid = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_valid = 1'b0;
    logic         loop_en = 1'b0;
    logic         freq_ok = 1'b0;
    logic [QW-1:0] qual_words = 4'd3;
    logic         run_viol;
    logic         lock_to_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int m_run = 0;
    bit m_pol = 1'b0;
    bit m_viol = 1'b0;
    bit m_lock = 1'b0;
    int m_cnt = 0;

    logic stream [0:511];
    int   n_bits;

    always #2 clk = ~clk;

    rl_lock_ctrl #(.WORD_W(W), .RUN_LIMIT(LIMIT), .QUAL_W(QW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .rx_valid(rx_valid),
        .tx_word(tx_word), .tx_valid(tx_valid), .loop_en(loop_en),
        .freq_ok(freq_ok), .qual_words(qual_words),
        .run_viol(run_viol), .lock_to_data(lock_to_data));

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_run = 0; m_pol = 1'b0; m_viol = 1'b0; m_lock = 1'b0; m_cnt = 0;
    endtask

    // Apply the current inputs for one clock, update the model, compare.
    task automatic step(input string tag);
        bit v;
        logic [W-1:0] w;
        bit hit;
        int tgt;
        v   = loop_en ? tx_valid : rx_valid;
        w   = loop_en ? tx_word : rx_word;
        hit = 1'b0;
        if (v) begin
            for (int i = 0; i < W; i++) begin
                if (w[i] == m_pol) m_run++;
                else begin m_pol = w[i]; m_run = 1; end
                if (m_run >= LIMIT) hit = 1'b1;
            end
            m_viol = hit;
        end
        tgt = (qual_words == 0) ? 1 : int'(qual_words);
        if (m_lock) begin
            if (!freq_ok || (v && hit)) m_lock = 1'b0;
            m_cnt = 0;
        end else if (!freq_ok || (v && hit)) begin
            m_cnt = 0;
        end else if (v) begin
            if (m_cnt + 1 >= tgt) begin m_lock = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end
        @(posedge clk);
        #1;
        check(tag, run_viol, m_viol, "run_viol");
        check(tag, lock_to_data, m_lock, "lock_to_data");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_valid = 1'b0; tx_valid = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        model_reset();
        rst_n = 1'b1;
    endtask

    task automatic put_word(input logic [W-1:0] w, input string tag);
        rx_word = w; rx_valid = 1'b1;
        step(tag);
        rx_valid = 1'b0;
    endtask

    // Stream: alternating prefix of off bits, run of len bits of pol, alternating tail.
    task automatic build(input int len, input int off, input bit pol);
        n_bits = 0;
        for (int i = 0; i < off; i++) begin
            stream[n_bits] = pol ^ (((off - 1 - i) % 2) == 0); n_bits++;
        end
        for (int i = 0; i < len; i++) begin stream[n_bits] = pol; n_bits++; end
        for (int i = 0; i < 10 || (n_bits % W) != 0; i++) begin
            stream[n_bits] = ~pol ^ (i % 2); n_bits++;
        end
    endtask

    task automatic feed(input bit gaps, input string tag);
        logic [W-1:0] w;
        for (int k = 0; k < n_bits / W; k++) begin
            for (int b = 0; b < W; b++) w[b] = stream[k*W + b];
            put_word(w, tag);
            if (gaps) begin
                rx_word = ~w; rx_valid = 1'b0;
                step(tag);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1", run_viol, 1'b0, "run_viol after reset");
        check("R1", lock_to_data, 1'b0, "lock after reset");

        // R7: qualification with alternating data
        freq_ok = 1'b1; qual_words = 4'd3;
        put_word(10'h155, "R7"); put_word(10'h2AA, "R7");
        check("R7", lock_to_data, 1'b0, "lock before 3rd word");
        put_word(10'h155, "R7");
        check("R7", lock_to_data, 1'b1, "lock after 3rd word");

        // R8: frequency loss drops lock
        freq_ok = 1'b0; step("R8");
        check("R8", lock_to_data, 1'b0, "lock after freq loss");
        freq_ok = 1'b1;

        // R7: qual 0 acts as 1
        qual_words = 4'd0;
        put_word(10'h2AA, "R7");
        check("R7", lock_to_data, 1'b1, "lock with qual 0");

        // R2 R3 R4: sweep lengths, offsets, polarity
        qual_words = 4'd2;
        for (int pol = 0; pol < 2; pol++)
            for (int off = 1; off <= W; off++)
                for (int len = LIMIT - 2; len <= LIMIT + 2; len++) begin
                    build(len, off, pol[0]);
                    feed(1'b0, len < LIMIT ? "R3" : "R2R4");
                end

        // R5: gaps in valid with junk words
        for (int off = 1; off <= 3; off++) begin
            build(LIMIT, off, 1'b0); feed(1'b1, "R5");
            build(LIMIT - 1, off, 1'b1); feed(1'b1, "R5");
        end

        // R6: loopback; rx would violate, tx alternating
        loop_en = 1'b1; tx_valid = 1'b1; rx_valid = 1'b1; rx_word = '0;
        for (int k = 0; k < 14; k++) begin
            tx_word = k[0] ? 10'h155 : 10'h2AA; step("R6");
        end
        check("R6", run_viol, 1'b0, "rx ignored in loopback");
        tx_word = '0;
        for (int k = 0; k < 12; k++) step("R6");
        check("R6", run_viol, 1'b1, "tx run seen in loopback");
        tx_valid = 1'b0; rx_valid = 1'b0; loop_en = 1'b0;
        put_word(10'h155, "R6");

        // R9: violation on the word that would complete qualification
        do_reset();
        freq_ok = 1'b1; qual_words = 4'd13;
        put_word(10'h200, "R9");
        for (int k = 0; k < 12; k++) put_word(10'h000, "R9");
        check("R9", run_viol, 1'b1, "flag on coinciding word");
        check("R9", lock_to_data, 1'b0, "no lock on coinciding word");

        // R10: freq loss together with a good word restarts qualification
        do_reset();
        freq_ok = 1'b1; qual_words = 4'd3;
        put_word(10'h155, "R10"); put_word(10'h2AA, "R10");
        freq_ok = 1'b0; put_word(10'h155, "R10");
        freq_ok = 1'b1;
        put_word(10'h2AA, "R10"); put_word(10'h155, "R10");
        check("R10", lock_to_data, 1'b0, "count restarted");
        put_word(10'h2AA, "R10");
        check("R10", lock_to_data, 1'b1, "lock after fresh 3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule